// File: doc/BRIEF.md
# I2C Target Register-Access Port

This block is an I2C target that gives a bus controller byte-wide read and write access to a 256-location register space. Both bus lines are oversampled in the system clock domain. SCL is an input only. SDA is open-drain, so it is modelled as an input level plus an output enable: while the enable is high, the pad pulls the line low. The block finds START and STOP conditions and matches its 7-bit device address. The upper six address bits are fixed at binary 101000, and the lowest bit comes from the strap input `strap_a0`. It then decodes the direction bit and runs the register transfer.

In a write, the first data byte after the address loads an internal register pointer. Each later byte is written at the pointer, and the pointer then steps forward, wrapping from 0xFF to 0x00. In a read, bytes are fetched from the pointer with the same auto-increment and shifted out most significant bit first, for as long as the controller acknowledges them. The register bank sits outside the block behind a single-cycle strobe bus: a pointer, write data, a write strobe, a read request, and read data that is returned one clock later. Locations 0x40 to 0xEF are holes in the map. The block never strobes the bank for them.

The control state machine has twelve states:
- ST_IDLE: the bus is free.
- ST_ADDR: shifting in the address byte.
- ST_AACK: driving the address acknowledge.
- ST_PTR: shifting in the pointer byte.
- ST_PACK: driving the pointer acknowledge.
- ST_WDATA: shifting in a write data byte.
- ST_WACK: driving the write acknowledge.
- ST_RFETCH: issuing the read request.
- ST_RLOAD: capturing the read data.
- ST_RDATA: shifting a byte out.
- ST_RACK: sampling the controller's acknowledge.
- ST_WAIT: SDA released until the next bus condition.

The transitions are as follows:
- A START leads from any state to ST_ADDR. A STOP leads from any state to ST_IDLE.
- ST_ADDR goes to ST_AACK on a match and to ST_WAIT on a mismatch, at the SCL fall after the eighth bit.
- ST_AACK goes to ST_PTR for a write or to ST_RFETCH for a read, at the SCL fall.
- ST_PTR goes to ST_PACK, and ST_PACK goes to ST_WDATA.
- ST_WDATA and ST_WACK alternate.
- ST_RFETCH goes to ST_RLOAD and then to ST_RDATA, one clock each.
- ST_RDATA goes to ST_RACK after the eighth SCL fall.
- ST_RACK goes to ST_RFETCH on ACK or to ST_WAIT on NACK.

Top module: `i2c_regport`

## Requirements
- R1: The target changes the SDA output enable only while SCL is low. Each read bit is placed after an SCL fall, so it is stable at the following rise.
- R2: An address byte after a START is acknowledged when its upper seven bits equal binary 101000 followed by the `strap_a0` level. An acknowledge is a low level on the 9th bit. The address byte's LSB selects the direction, with 1 for read and 0 for write.
- R3: On an address mismatch the 9th bit is left high (NACK), and SDA stays released for all later clocks until the next START.
- R4: The first byte written after a matching write address loads the register pointer. It is acknowledged and causes no register write.
- R5: Each later written byte is received MSB first, acknowledged, and written at the pointer. The pointer then increments, wrapping from 0xFF to 0x00.
- R6: Read bytes are fetched from the pointer and sent MSB first. The pointer increments after each byte, and a controller ACK (low 9th bit) continues the read with the next location.
- R7: After the controller NACKs a read byte (high 9th bit), the target releases SDA. It issues no further read requests until a STOP or a START.
- R8: Locations 0x40 to 0xEF are reserved. Writes to them are acknowledged but produce no write strobe, and reads of them return 0x00 with no read request.
- R9: A repeated START restarts the address phase. A STOP returns the target to idle with SDA released, and bytes clocked while idle are not acknowledged.
- R10: During and right after reset, the SDA enable, write strobe and read request are all low.
- R11: Every register-bus strobe lasts one clock, and the write strobe and read request are never high together. Read data is taken one clock after the read request, and there is one read request per byte sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | SDA pull-low enable (1 = drive low) |
| strap_a0 | input | 1 | Address strap giving the device address LSB |
| reg_addr | output | 8 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Write data to the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read request |
| reg_rdata | input | 8 | Read data, valid the clock after reg_re |

## Verification
The main transfer path is tried with a table of pointer and data pairs. Each pair is written and then read back. Some pairs sit at the ends of the user region, some at the edges of the reserved hole, and some at the top of the map, which separates a real write from one that is silently discarded. A burst across 0xFE to 0x00, written and then read with a repeated START, separates correct pointer wrap and auto-increment from a stuck or unwrapped pointer. Further patterns cover these cases:
- an address that is wrong in the strap bit alone, and the strap-correct address;
- bytes clocked after a NACK;
- bytes clocked after a STOP.

These show whether the target matches only its exact address and releases the line whenever it should.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    // Control states of the target engine
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_WDATA,
        ST_WACK,
        ST_RFETCH,
        ST_RLOAD,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } rp_state_e;

    // Bits per bus byte, fixed by the protocol
    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/i2c_rp_sync.sv
// Multi-stage synchronisers with edge detection for a group of bus lines.
module i2c_rp_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~prev;
        assign fall[g] = ~chain[STAGES-1] & prev;
    end

endmodule

// File: rtl/i2c_rp_cond.sv
// START / STOP recognition: an SDA edge while SCL is high.
module i2c_rp_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_det,
    output logic stop_det
);

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;

endmodule

// File: rtl/i2c_rp_map.sv
// Decodes the fixed hole in the register map.
module i2c_rp_map #(
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] RSV_LO = 8'h40,
    parameter logic [AW-1:0] RSV_HI = 8'hEF
) (
    input  logic [AW-1:0] ptr,
    output logic          rsv
);

    logic above_lo;
    logic below_hi;

    assign above_lo = (ptr >= RSV_LO);
    assign below_hi = (ptr <= RSV_HI);
    assign rsv      = above_lo & below_hi;

endmodule

// File: rtl/i2c_rp_fsm.sv
// Protocol engine: address match, pointer load, write and read phases.
module i2c_rp_fsm
    import i2c_rp_pkg::*;
#(
    parameter int unsigned AW      = 8,
    parameter logic [5:0]  ADDR_HI = 6'b101000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          strap_a0,
    input  logic          rsv,
    input  logic [7:0]    reg_rdata,
    output logic          sda_oe,
    output logic          reg_we,
    output logic          reg_re,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata
);

    localparam int unsigned CW = $clog2(BYTE_BITS + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_BITS - 1);

    rp_state_e       state_q;
    rp_state_e       state_d;
    logic [7:0]      sh_q;
    logic [CW-1:0]   cnt_q;
    logic [AW-1:0]   ptr_q;
    logic            mack_q;
    logic            byte_done;
    logic            addr_hit;
    logic            shifting_in;

    assign byte_done = (cnt_q == CNT_FULL);
    assign addr_hit  = (sh_q[7:1] == {ADDR_HI, strap_a0});

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_WAIT:   state_d = ST_WAIT;
                ST_ADDR: begin
                    if (scl_fall && byte_done) begin
                        state_d = addr_hit ? ST_AACK : ST_WAIT;
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        state_d = sh_q[0] ? ST_RFETCH : ST_PTR;
                    end
                end
                ST_PTR: begin
                    if (scl_fall && byte_done) begin
                        state_d = ST_PACK;
                    end
                end
                ST_PACK: begin
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_fall && byte_done) begin
                        state_d = ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                    end
                end
                ST_RFETCH: state_d = ST_RLOAD;
                ST_RLOAD:  state_d = ST_RDATA;
                ST_RDATA: begin
                    if (scl_fall && (cnt_q == CNT_LAST)) begin
                        state_d = ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        state_d = mack_q ? ST_RFETCH : ST_WAIT;
                    end
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- data registers ----------------
    assign shifting_in = (state_q == ST_ADDR) || (state_q == ST_PTR) ||
                         (state_q == ST_WDATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            ptr_q  <= '0;
            mack_q <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q  <= '0;
        end else if (shifting_in) begin
            if (scl_rise && !byte_done) begin
                sh_q  <= {sh_q[6:0], sda_lvl};
                cnt_q <= cnt_q + CW'(1);
            end else if (scl_fall && byte_done) begin
                cnt_q <= '0;
                if (state_q == ST_PTR) begin
                    ptr_q <= AW'(sh_q);
                end else if (state_q == ST_WDATA) begin
                    ptr_q <= ptr_q + AW'(1);
                end
            end
        end else begin
            case (state_q)
                ST_RLOAD: begin
                    sh_q  <= rsv ? 8'h00 : reg_rdata;
                    ptr_q <= ptr_q + AW'(1);
                    cnt_q <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        sh_q  <= {sh_q[6:0], 1'b0};
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_lvl;
                    end
                end
                default: begin
                    cnt_q <= cnt_q;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sda_oe = 1'b0;
        reg_we = 1'b0;
        reg_re = 1'b0;
        unique case (state_q)
            ST_AACK, ST_PACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:                  sda_oe = ~sh_q[7];
            ST_RFETCH:                 reg_re = ~rsv;
            ST_WDATA:                  reg_we = scl_fall & byte_done & ~rsv;
            default:                   sda_oe = 1'b0;
        endcase
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = sh_q;

endmodule

// File: rtl/i2c_regport.sv
// I2C target giving byte access to a 256-location register space.
module i2c_regport #(
    parameter int unsigned   SYNC_STAGES = 2,
    parameter logic [5:0]    ADDR_HI     = 6'b101000,
    parameter logic [7:0]    RSV_LO      = 8'h40,
    parameter logic [7:0]    RSV_HI      = 8'hEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       strap_a0,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    input  logic [7:0] reg_rdata
);

    localparam int unsigned NLINES = 2;
    localparam int unsigned L_SCL  = 0;
    localparam int unsigned L_SDA  = 1;

    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] fall;
    logic              scl_lvl;
    logic              start_det;
    logic              stop_det;
    logic              rsv;

    i2c_rp_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (NLINES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_i, scl_i}),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    assign scl_lvl = lvl[L_SCL];

    i2c_rp_cond u_cond (
        .scl_lvl   (scl_lvl),
        .sda_rise  (rise[L_SDA]),
        .sda_fall  (fall[L_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rp_map #(
        .AW     (8),
        .RSV_LO (RSV_LO),
        .RSV_HI (RSV_HI)
    ) u_map (
        .ptr (reg_addr),
        .rsv (rsv)
    );

    i2c_rp_fsm #(
        .AW      (8),
        .ADDR_HI (ADDR_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (rise[L_SCL]),
        .scl_fall  (fall[L_SCL]),
        .sda_lvl   (lvl[L_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_a0  (strap_a0),
        .rsv       (rsv),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

endmodule

// File: rtl/i2c_regport_chk.sv
// Property checker bound to the register-access target.
module i2c_regport_chk #(
    parameter logic [7:0] RSV_LO = 8'h40,
    parameter logic [7:0] RSV_HI = 8'hEF
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       reg_we,
    input logic       reg_re,
    input logic [7:0] reg_addr
);

    a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    a_r8_hole_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> ((reg_addr < RSV_LO) || (reg_addr > RSV_HI)));

    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe);

    a_r11_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    a_r11_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr)
);

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam int H = 16;
    localparam int NVEC = 6;
    // {pointer, write data, expected read}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'h3C, 8'h3C},
        {8'h3F, 8'hA5, 8'hA5},
        {8'h40, 8'h77, 8'h00},
        {8'hEF, 8'h12, 8'h00},
        {8'hF0, 8'hC3, 8'hC3},
        {8'hFF, 8'h81, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       ctrl_sda = 1'b1;
    logic       strap = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] reg_rdata;

    logic [7:0] mem [256];
    int         we_cnt = 0;
    int         re_cnt = 0;
    int         r1_viol = 0;
    logic       oe_prev = 1'b0;
    logic       oe_seen = 1'b0;
    int         tests = 0;
    int         fails = 0;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = ctrl_sda & ~sda_oe;

    i2c_regport dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_a0  (strap),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    // Register bank model with one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            reg_rdata <= 8'h00;
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (reg_re) begin
                reg_rdata <= mem[reg_addr];
                re_cnt <= re_cnt + 1;
            end
        end
    end

    // R1 monitor: enable may only move while SCL is low
    always @(posedge clk) begin
        if (rst_n) begin
            if ((sda_oe != oe_prev) && scl) r1_viol <= r1_viol + 1;
            if (sda_oe) oe_seen <= 1'b1;
        end
        oe_prev <= sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] abyte(input logic a0, input logic rw);
        return {6'b101000, a0, rw};
    endfunction

    task automatic bus_start;
        ctrl_sda = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        ctrl_sda = 1'b0; tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic bus_stop;
        ctrl_sda = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        ctrl_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            ctrl_sda = b[i]; tick(Q);
            scl = 1'b1;      tick(H);
            scl = 1'b0;      tick(Q);
        end
        ctrl_sda = 1'b1; tick(Q);
        scl = 1'b1;      tick(H/2);
        acked = ~sda_line;
        tick(H/2);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        ctrl_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(H/2);
            b[i] = sda_line;
            tick(H/2);
            scl = 1'b0; tick(Q);
        end
        ctrl_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(Q);
        ctrl_sda = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] p, input logic [7:0] d, output logic all_ack);
        logic a0, a1, a2;
        bus_start;
        send_byte(abyte(strap, 1'b0), a0);
        send_byte(p, a1);
        send_byte(d, a2);
        bus_stop;
        all_ack = a0 & a1 & a2;
    endtask

    task automatic read_one(input logic [7:0] p, output logic [7:0] d);
        logic a;
        bus_start;
        send_byte(abyte(strap, 1'b0), a);
        send_byte(p, a);
        bus_start;
        send_byte(abyte(strap, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic       ack2;
        logic [7:0] rd;
        int         we0;
        int         re0;

        tick(5);
        // R10: reset state
        check("R10 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
        check("R10 strobes in reset", {30'd0, reg_we, reg_re}, 32'd0);
        rst_n = 1'b1;
        tick(4);
        check("R10 sda_oe after reset", {31'd0, sda_oe}, 32'd0);

        // Table walk: write then read back each vector
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] p, d, e;
            logic       hole;
            p = VEC[k][23:16];
            d = VEC[k][15:8];
            e = VEC[k][7:0];
            hole = (p >= 8'h40) && (p <= 8'hEF);
            we0 = we_cnt;
            write_one(p, d, ack);
            check(hole ? "R8 reserved write acked" : "R5 write acked", {31'd0, ack}, 32'd1);
            check(hole ? "R8 no write strobe" : "R5 one write strobe",
                  32'(we_cnt - we0), hole ? 32'd0 : 32'd1);
            re0 = re_cnt;
            read_one(p, rd);
            check(hole ? "R8 reserved reads zero" : "R6 read back", {24'd0, rd}, {24'd0, e});
            check(hole ? "R8 no read request" : "R11 one read request",
                  32'(re_cnt - re0), hole ? 32'd0 : 32'd1);
        end

        // R4: pointer-only write loads pointer, no write strobe
        we0 = we_cnt;
        bus_start;
        send_byte(abyte(strap, 1'b0), ack);
        send_byte(8'h10, ack2);
        bus_stop;
        check("R4 pointer byte acked", {31'd0, ack2}, 32'd1);
        check("R4 pointer byte writes nothing", 32'(we_cnt - we0), 32'd0);
        bus_start;
        send_byte(abyte(strap, 1'b1), ack);
        recv_byte(1'b0, rd);
        bus_stop;
        check("R4 read at loaded pointer", {24'd0, rd}, {24'd0, 8'h10 ^ 8'h5A});

        // R3: address wrong only in strap bit
        bus_start;
        oe_seen = 1'b0;
        send_byte(abyte(~strap, 1'b0), ack);
        send_byte(8'h00, ack2);
        send_byte(8'h55, ack2);
        check("R3 mismatch not acked", {31'd0, ack}, 32'd0);
        check("R3 SDA stays released", {31'd0, oe_seen}, 32'd0);
        bus_stop;

        // R2: strap high changes the matched address
        strap = 1'b1;
        tick(4);
        bus_start;
        send_byte(8'hA0, ack);
        bus_stop;
        check("R2 old address ignored with strap high", {31'd0, ack}, 32'd0);

        // R5 wrap burst FE, FF, 00
        we0 = we_cnt;
        bus_start;
        send_byte(8'hA2, ack);
        check("R2 strap-high address acked", {31'd0, ack}, 32'd1);
        send_byte(8'hFE, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack2);
        bus_stop;
        check("R5 burst last byte acked", {31'd0, ack2}, 32'd1);
        check("R5 three writes", 32'(we_cnt - we0), 32'd3);

        // R6/R9: repeated START read burst with wrap
        re0 = re_cnt;
        bus_start;
        send_byte(8'hA2, ack);
        send_byte(8'hFE, ack);
        bus_start;
        send_byte(8'hA3, ack);
        check("R9 repeated START address acked", {31'd0, ack}, 32'd1);
        recv_byte(1'b1, rd);
        check("R6 burst byte 0xFE", {24'd0, rd}, 32'h11);
        recv_byte(1'b1, rd);
        check("R6 burst byte 0xFF", {24'd0, rd}, 32'h22);
        recv_byte(1'b0, rd);
        check("R6 burst byte wrapped 0x00", {24'd0, rd}, 32'h33);
        check("R11 one request per byte", 32'(re_cnt - re0), 32'd3);

        // R7: after NACK the line stays released
        re0 = re_cnt;
        oe_seen = 1'b0;
        recv_byte(1'b0, rd);
        check("R7 line released after NACK", {24'd0, rd}, 32'hFF);
        check("R7 no request after NACK", 32'(re_cnt - re0), 32'd0);
        check("R7 enable never set after NACK", {31'd0, oe_seen}, 32'd0);
        bus_stop;

        // R9: STOP goes idle; bytes without START are ignored
        check("R9 released after STOP", {31'd0, sda_oe}, 32'd0);
        scl = 1'b0;
        tick(Q);
        send_byte(8'hA2, ack);
        check("R9 idle byte not acked", {31'd0, ack}, 32'd0);
        bus_stop;

        // R1 monitor result
        check("R1 enable changes only with SCL low", r1_viol, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule